// File: doc/BRIEF.md
# Free-Running Timer with Output Compares

This peripheral keeps a 16-bit up-counter running from the bus clock, passed through a divider that software picks. It also holds a set of 16-bit compare values. When the counter steps onto one of those values, a per-channel flag is set. When the counter rolls over from its top value to zero, an overflow flag is set. A channel asks for service only while both its flag and its mask bit are set. The block drives a level request plus a source number and a vector address, so a processor can fetch the handler that matches.

Software reaches the block over a simple synchronous byte bus. Each access is a 16-bit address with a write strobe or a read strobe. The block answers only when the upper address bits match its base parameter; the low six bits select the register. Read data is registered and appears the cycle after the read strobe. Flags are cleared by writing ones to them. Reading the counter's upper byte freezes a copy of its lower byte, so a two-byte read returns one consistent value. Writing the upper byte of a compare value suspends that channel until its lower byte has also been written.

Top module: `tmr_main`

## Requirements
- R1: After reset the counter, all flags, the mask, the overflow enable and the prescale code are zero, every compare value is 0xFFFF, read data is zero and no request is raised.
- R2: The counter advances by one every 1, 4, 8 or 16 bus cycles for prescale codes 0, 1, 2 and 3 (control offset 0x24, bits 1:0) and wraps from 0xFFFF to 0x0000.
- R3: Compare channel k (k = 1..5, value bytes at offsets 0x14+2k upper and 0x15+2k lower) sets flag bit 8-k of offset 0x23 on the edge where the counter steps onto its value; channel 2 is bit 0x40.
- R4: Writing a 1 to a flag bit clears it, writing 0 leaves it unchanged, and a new match in the same cycle wins over the clear.
- R5: A counter wrap sets the overflow flag (offset 0x25, bit 7); it is cleared only by writing a 1 to that bit.
- R6: The request output is high exactly while some channel has both its flag and its mask bit set (offset 0x22, same bit positions as the flags), or while the overflow flag and its enable (offset 0x24, bit 7) are both set.
- R7: The source number names the lowest-numbered pending compare channel (1..5), or 6 for overflow when no compare is pending, and is 0 when nothing is pending.
- R8: The vector output is 0xFFE8 - 2*(source-1) while a source is pending, so channel 2 gives 0xFFE6 and overflow gives 0xFFDE, and it is 0x0000 otherwise.
- R9: Only addresses from BASE to BASE+0x3F are decoded. Other addresses change no state and leave the read data as it was. Read data appears one cycle after the read strobe.
- R10: Reading the counter's upper byte (offset 0x0E) latches the lower byte, and the next read of offset 0x0F returns that latched byte. Without a pending latch, offset 0x0F returns the live lower byte.
- R11: After a write to a compare's upper byte, that channel cannot match until its lower byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |
| irq_src | output | 3 | Pending source number, 0 when idle |
| irq_vector | output | 16 | Vector address of the pending source |

## Verification
The assertions assume that reset is held low from time zero. They also assume that a cycle never carries both a read strobe and a write strobe. Under those conditions they treat every flag drop as the result of a clear written the cycle before, and every counter change as a single step. The stimulus drives the bus only between clock edges and uses one strobe at a time. It places compare targets a fixed number of counts ahead of the model's counter, so each match lands inside the waiting window. It waits out a full counter period so that overflow is reached through real counting and never forced.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the free-running timer.
// Assumes a byte-wide register bus with a 6-bit register offset.
package tmr_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 6;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int SRC_W  = 3;

    localparam logic [OFF_W-1:0] OFF_CNT_HI  = 6'h0E;
    localparam logic [OFF_W-1:0] OFF_CNT_LO  = 6'h0F;
    localparam logic [OFF_W-1:0] OFF_OC_BASE = 6'h16;
    localparam logic [OFF_W-1:0] OFF_MASK    = 6'h22;
    localparam logic [OFF_W-1:0] OFF_FLAG    = 6'h23;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 6'h24;
    localparam logic [OFF_W-1:0] OFF_STAT    = 6'h25;

    typedef enum logic [1:0] {
        PRE_DIV1  = 2'd0,
        PRE_DIV4  = 2'd1,
        PRE_DIV8  = 2'd2,
        PRE_DIV16 = 2'd3
    } prescale_e;

    // Last prescaler count before a counter step, per divide code.
    function automatic logic [PRE_W-1:0] pre_limit(input prescale_e code);
        case (code)
            PRE_DIV1:  return PRE_W'(0);
            PRE_DIV4:  return PRE_W'(3);
            PRE_DIV8:  return PRE_W'(7);
            default:   return PRE_W'(15);
        endcase
    endfunction
endpackage

// File: rtl/tmr_counter.sv
// Prescaler plus free-running up-counter.
// Produces a one-cycle tick whenever the counter steps, the value it steps to,
// and a wrap pulse coincident with the 0xFFFF -> 0x0000 step.
// Assumes pre_sel may change at any time; a lowered limit takes effect at once.
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  prescale_e        pre_sel,
    output logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    logic [PRE_W-1:0] pre_q;

    assign tick    = (pre_q >= pre_limit(pre_sel));
    assign cnt_nxt = cnt + CNT_W'(1);
    assign wrap    = tick && (cnt == {CNT_W{1'b1}});

    // Divide the bus clock down to the counting rate.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
    end

    // Step the main counter on each prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt_nxt;
    end
endmodule

// File: rtl/tmr_compare_bank.sv
// Bank of output-compare registers, one per channel.
// Each channel compares its value with the counter's next value on a tick, so
// a match is reported on the edge where the counter reaches the value.
// An upper-byte write arms a block that suppresses matches until the lower
// byte arrives.
module tmr_compare_bank
    import tmr_pkg::*;
#(
    parameter int NUM_OC = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_OC-1:0]       hi_we,
    input  logic [NUM_OC-1:0]       lo_we,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    tick,
    input  logic [CNT_W-1:0]        cnt_nxt,
    output logic [NUM_OC*CNT_W-1:0] oc_flat,
    output logic [NUM_OC-1:0]       match
);
    for (genvar g = 0; g < NUM_OC; g++) begin : g_chan
        logic [CNT_W-1:0] oc_q;
        logic             blk_q;

        // Byte-wise update of the compare value and its write block.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oc_q  <= {CNT_W{1'b1}};
                blk_q <= 1'b0;
            end else if (hi_we[g]) begin
                oc_q[CNT_W-1:DATA_W] <= wdata;
                blk_q                <= 1'b1;
            end else if (lo_we[g]) begin
                oc_q[DATA_W-1:0] <= wdata;
                blk_q            <= 1'b0;
            end
        end

        assign match[g] = tick && !blk_q && (cnt_nxt == oc_q);
        assign oc_flat[g*CNT_W +: CNT_W] = oc_q;
    end
endmodule

// File: rtl/tmr_irq_encoder.sv
// Priority encoder from pending sources to request, source number and vector.
// Compare channels win over overflow, lowest channel first. Source 0 = idle,
// 1..NUM_OC = compare channels, NUM_OC+1 = overflow. Vectors descend by two
// bytes from VEC_TOP.
module tmr_irq_encoder
    import tmr_pkg::*;
#(
    parameter int          NUM_OC  = 5,
    parameter logic [15:0] VEC_TOP = 16'hFFE8
) (
    input  logic [NUM_OC-1:0] oc_pend,
    input  logic              ovf_pend,
    output logic              irq,
    output logic [SRC_W-1:0]  src,
    output logic [15:0]       vector
);
    localparam logic [SRC_W-1:0] SRC_OVF = SRC_W'(NUM_OC + 1);

    // Pick the highest-priority pending source.
    always_comb begin
        src = '0;
        if (ovf_pend) src = SRC_OVF;
        for (int i = NUM_OC - 1; i >= 0; i--) begin
            if (oc_pend[i]) src = SRC_W'(i + 1);
        end
    end

    // Translate the source number into its vector address.
    always_comb begin
        if (src == '0) vector = '0;
        else           vector = VEC_TOP - 16'({src - SRC_W'(1), 1'b0});
    end

    assign irq = (src != '0);
endmodule

// File: rtl/tmr_main.sv
// Memory-mapped main timer: register decode, flag/mask/control state, read
// path with coherent counter read, and glue to counter, compare bank and
// interrupt encoder. Assumes bus_rd and bus_wr are not asserted together.
// Flag register bit (7-i) belongs to compare channel i+1.
module tmr_main
    import tmr_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h1000,
    parameter int          NUM_OC    = 5,
    parameter logic [15:0] VEC_TOP   = 16'hFFE8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    output logic [2:0]  irq_src,
    output logic [15:0] irq_vector
);
    logic                    sel, wr_sel, rd_sel;
    logic [OFF_W-1:0]        off;
    logic [NUM_OC-1:0]       hi_we, lo_we, match;
    logic [NUM_OC-1:0]       mask_q, flag_q, flag_clr;
    logic                    ovf_q, ovf_en_q, flag_wr, stat_wr, ctrl_wr, mask_wr;
    prescale_e               pre_q;
    logic                    tick, wrap;
    logic [CNT_W-1:0]        cnt_q, cnt_nxt;
    logic [NUM_OC*CNT_W-1:0] oc_flat;
    logic [DATA_W-1:0]       rd_val, lo_lat_q;
    logic                    lo_vld_q;

    // Channel vector to register byte, channel i at bit 7-i.
    function automatic logic [DATA_W-1:0] ch_to_byte(input logic [NUM_OC-1:0] v);
        logic [DATA_W-1:0] b;
        b = '0;
        for (int i = 0; i < NUM_OC; i++) b[DATA_W-1-i] = v[i];
        return b;
    endfunction

    // Register byte to channel vector.
    function automatic logic [NUM_OC-1:0] byte_to_ch(input logic [DATA_W-1:0] b);
        logic [NUM_OC-1:0] v;
        for (int i = 0; i < NUM_OC; i++) v[i] = b[DATA_W-1-i];
        return v;
    endfunction

    // Offset of a compare byte; lo selects the lower byte.
    function automatic logic [OFF_W-1:0] oc_off(input int ch, input int lo);
        return OFF_W'(int'(OFF_OC_BASE) + 2 * ch + lo);
    endfunction

    assign sel     = (bus_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
    assign off     = bus_addr[OFF_W-1:0];
    assign wr_sel  = bus_wr && sel;
    assign rd_sel  = bus_rd && sel;
    assign flag_wr = wr_sel && (off == OFF_FLAG);
    assign stat_wr = wr_sel && (off == OFF_STAT);
    assign ctrl_wr = wr_sel && (off == OFF_CTRL);
    assign mask_wr = wr_sel && (off == OFF_MASK);

    for (genvar g = 0; g < NUM_OC; g++) begin : g_we
        assign hi_we[g] = wr_sel && (off == oc_off(g, 0));
        assign lo_we[g] = wr_sel && (off == oc_off(g, 1));
    end

    tmr_counter u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_sel (pre_q),
        .tick    (tick),
        .cnt     (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    tmr_compare_bank #(.NUM_OC(NUM_OC)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_we   (hi_we),
        .lo_we   (lo_we),
        .wdata   (bus_wdata),
        .tick    (tick),
        .cnt_nxt (cnt_nxt),
        .oc_flat (oc_flat),
        .match   (match)
    );

    tmr_irq_encoder #(.NUM_OC(NUM_OC), .VEC_TOP(VEC_TOP)) u_encoder (
        .oc_pend  (flag_q & mask_q),
        .ovf_pend (ovf_q && ovf_en_q),
        .irq      (irq),
        .src      (irq_src),
        .vector   (irq_vector)
    );

    assign flag_clr = flag_wr ? byte_to_ch(bus_wdata) : '0;

    // Mask and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            ovf_en_q <= 1'b0;
            pre_q    <= PRE_DIV1;
        end else begin
            if (mask_wr) mask_q <= byte_to_ch(bus_wdata);
            if (ctrl_wr) begin
                ovf_en_q <= bus_wdata[DATA_W-1];
                pre_q    <= prescale_e'(bus_wdata[1:0]);
            end
        end
    end

    // Compare flags: set by match, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~flag_clr) | match;
    end

    // Overflow flag: set by wrap, cleared by writing one to bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= (ovf_q && !(stat_wr && bus_wdata[DATA_W-1])) || wrap;
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        rd_val = '0;
        case (off)
            OFF_CNT_HI: rd_val = cnt_q[CNT_W-1:DATA_W];
            OFF_CNT_LO: rd_val = lo_vld_q ? lo_lat_q : cnt_q[DATA_W-1:0];
            OFF_MASK:   rd_val = ch_to_byte(mask_q);
            OFF_FLAG:   rd_val = ch_to_byte(flag_q);
            OFF_CTRL:   rd_val = {ovf_en_q, 5'b0, pre_q};
            OFF_STAT:   rd_val = {ovf_q, 7'b0};
            default:    rd_val = '0;
        endcase
        for (int i = 0; i < NUM_OC; i++) begin
            if (off == oc_off(i, 0)) rd_val = oc_flat[i*CNT_W+DATA_W +: DATA_W];
            if (off == oc_off(i, 1)) rd_val = oc_flat[i*CNT_W +: DATA_W];
        end
    end

    // Registered read data; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_sel) bus_rdata <= rd_val;
    end

    // Lower-byte latch for a coherent two-byte counter read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_lat_q <= '0;
            lo_vld_q <= 1'b0;
        end else if (rd_sel && off == OFF_CNT_HI) begin
            lo_lat_q <= cnt_q[DATA_W-1:0];
            lo_vld_q <= 1'b1;
        end else if (rd_sel && off == OFF_CNT_LO) begin
            lo_vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_main_checker.sv
// Assertion checker for tmr_main, attached by bind below.
// Assumes reset is held low from time zero.
module tmr_main_checker #(
    parameter int          NUM_OC  = 5,
    parameter logic [15:0] VEC_TOP = 16'hFFE8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cnt,
    input logic [NUM_OC-1:0] flags,
    input logic [NUM_OC-1:0] mask,
    input logic              ovf,
    input logic              ovf_en,
    input logic              flag_wr,
    input logic              stat_wr,
    input logic              irq,
    input logic [2:0]        irq_src,
    input logic [15:0]       irq_vector
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 16'd1));

    assert_flag_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags) & ~flags)) |-> $past(flag_wr));

    assert_ovf_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt) == 16'hFFFF && cnt == 16'h0000) |-> ovf);

    assert_ovf_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(stat_wr));

    assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((|(flags & mask)) || (ovf && ovf_en)));

    assert_src_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (irq_src == 3'd0 && irq_vector == 16'h0000));

    assert_vec_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == 3'd2) |-> (irq_vector == VEC_TOP - 16'd2));
endmodule

bind tmr_main tmr_main_checker #(.NUM_OC(NUM_OC), .VEC_TOP(VEC_TOP)) u_tmr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt_q),
    .flags      (flag_q),
    .mask       (mask_q),
    .ovf        (ovf_q),
    .ovf_en     (ovf_en_q),
    .flag_wr    (flag_wr),
    .stat_wr    (stat_wr),
    .irq        (irq),
    .irq_src    (irq_src),
    .irq_vector (irq_vector)
);

// File: tb/tmr_main_bench.sv
// Bench for tmr_main: behavioural reference model compared every clock,
// plus directed checks with hand-derived values.
module tmr_main_bench;
    localparam int BASE = 16'h1000;
    localparam int NOC  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic [2:0]  irq_src;
    logic [15:0] irq_vector;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    // Reference model state
    int m_cnt, m_pre, m_code, m_mask, m_flags, m_ovf, m_ovfen;
    int m_rdata, m_latch, m_lvld;
    int m_oc[NOC];
    int m_blk[NOC];

    always #10 clk = ~clk;

    tmr_main u_tmr_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .irq_src    (irq_src),
        .irq_vector (irq_vector)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int byte2ch(input int b);
        int r = 0;
        for (int i = 0; i < NOC; i++) if (((b >> (7 - i)) & 1) != 0) r |= (1 << i);
        return r;
    endfunction

    function automatic int ch2byte(input int v);
        int r = 0;
        for (int i = 0; i < NOC; i++) if (((v >> i) & 1) != 0) r |= (1 << (7 - i));
        return r;
    endfunction

    function automatic int m_read(input int off);
        if (off == 'h0E) return (m_cnt >> 8) & 255;
        if (off == 'h0F) return (m_lvld != 0) ? m_latch : (m_cnt & 255);
        if (off == 'h22) return ch2byte(m_mask);
        if (off == 'h23) return ch2byte(m_flags);
        if (off == 'h24) return (m_ovfen << 7) | m_code;
        if (off == 'h25) return m_ovf << 7;
        for (int i = 0; i < NOC; i++) begin
            if (off == 'h16 + 2 * i) return (m_oc[i] >> 8) & 255;
            if (off == 'h17 + 2 * i) return m_oc[i] & 255;
        end
        return 0;
    endfunction

    function automatic int m_src();
        int p = m_flags & m_mask;
        for (int i = 0; i < NOC; i++) if (((p >> i) & 1) != 0) return i + 1;
        if (m_ovf != 0 && m_ovfen != 0) return NOC + 1;
        return 0;
    endfunction

    function automatic int m_vec();
        int s = m_src();
        return (s == 0) ? 0 : ('hFFE8 - 2 * (s - 1));
    endfunction

    // Model update on each rising edge, using values from before the edge.
    always @(posedge clk) begin
        int lim, nxt, setm, clr, ovfclr, off, d, rv;
        bit tick, wrapev, sel, w, r;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_code = 0; m_mask = 0; m_flags = 0;
            m_ovf = 0; m_ovfen = 0; m_rdata = 0; m_latch = 0; m_lvld = 0;
            for (int i = 0; i < NOC; i++) begin m_oc[i] = 'hFFFF; m_blk[i] = 0; end
        end else begin
            lim    = (m_code == 0) ? 0 : (m_code == 1) ? 3 : (m_code == 2) ? 7 : 15;
            tick   = (m_pre >= lim);
            nxt    = (m_cnt + 1) & 'hFFFF;
            wrapev = tick && (m_cnt == 'hFFFF);
            setm   = 0;
            for (int i = 0; i < NOC; i++)
                if (tick && m_blk[i] == 0 && nxt == m_oc[i]) setm |= (1 << i);
            sel = ((int'(bus_addr) >> 6) == (BASE >> 6));
            off = int'(bus_addr) & 63;
            d   = int'(bus_wdata);
            w   = bus_wr && sel;
            r   = bus_rd && sel;
            clr = 0; ovfclr = 0;
            if (r) begin
                rv = m_read(off);
                m_rdata = rv;
                if (off == 'h0E) begin m_latch = m_cnt & 255; m_lvld = 1; end
                else if (off == 'h0F) m_lvld = 0;
            end
            if (w) begin
                if (off == 'h22) m_mask = byte2ch(d);
                if (off == 'h23) clr = byte2ch(d);
                if (off == 'h24) begin m_ovfen = (d >> 7) & 1; m_code = d & 3; end
                if (off == 'h25) ovfclr = (d >> 7) & 1;
                for (int i = 0; i < NOC; i++) begin
                    if (off == 'h16 + 2 * i) begin m_oc[i] = (d << 8) | (m_oc[i] & 255); m_blk[i] = 1; end
                    if (off == 'h17 + 2 * i) begin m_oc[i] = (m_oc[i] & 'hFF00) | d; m_blk[i] = 0; end
                end
            end
            m_flags = (m_flags & ~clr) | setm;
            m_ovf   = ((m_ovf != 0 && ovfclr == 0) || wrapev) ? 1 : 0;
            m_pre   = tick ? 0 : m_pre + 1;
            m_cnt   = tick ? nxt : m_cnt;
        end
    end

    // Compare design outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(bus_rdata) == m_rdata, "R9 read data vs model", int'(bus_rdata), m_rdata);
            check(int'(irq) == ((m_src() != 0) ? 1 : 0), "R6 request vs model", int'(irq), (m_src() != 0) ? 1 : 0);
            check(int'(irq_src) == m_src(), "R7 source vs model", int'(irq_src), m_src());
            check(int'(irq_vector) == m_vec(), "R8 vector vs model", int'(irq_vector), m_vec());
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_errors++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected below 190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr_abs(input int addr, input int data);
        @(negedge clk);
        bus_addr = 16'(addr); bus_wdata = 8'(data); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic wr(input int off, input int data);
        wr_abs(BASE + off, data);
    endtask

    task automatic rd_abs(input int addr, output int v);
        @(negedge clk);
        bus_addr = 16'(addr); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 16'h0000;
        v = int'(bus_rdata);
    endtask

    task automatic rd_exp(input int off, input int exp, input string tag);
        int v;
        rd_abs(BASE + off, v);
        check(v == exp, tag, v, exp);
    endtask

    initial begin
        int v, a_hi, a_lo, b_hi, b_lo, t, diff;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(irq == 1'b0, "R1 request after reset", int'(irq), 0);
        rd_exp('h22, 'h00, "R1 mask after reset");
        rd_exp('h23, 'h00, "R1 flags after reset");
        rd_exp('h18, 'hFF, "R1 compare upper after reset");
        rd_exp('h19, 'hFF, "R1 compare lower after reset");
        rd_exp('h24, 'h00, "R1 control after reset");
        rd_exp('h25, 'h00, "R1 status after reset");

        // R2 and R10: counting rate at divide-by-1 and divide-by-16
        for (int code = 0; code < 4; code += 3) begin
            wr('h24, code);
            repeat (20) @(negedge clk);
            rd_abs(BASE + 'h0E, a_hi);
            rd_abs(BASE + 'h0F, a_lo);
            check(a_lo == m_rdata, "R10 latched lower byte", a_lo, m_rdata);
            repeat (156) @(negedge clk);
            rd_abs(BASE + 'h0E, b_hi);
            repeat (5) @(negedge clk);
            rd_abs(BASE + 'h0F, b_lo);
            diff = (((b_hi << 8) | b_lo) - ((a_hi << 8) | a_lo)) & 'hFFFF;
            check(diff == ((code == 0) ? 160 : 10), "R2 counts over 160 cycles",
                  diff, (code == 0) ? 160 : 10);
        end
        wr('h24, 1);
        repeat (30) @(negedge clk);
        rd_abs(BASE + 'h0E, v);
        check(v == m_rdata, "R2 counter upper at divide-by-4", v, m_rdata);
        wr('h24, 2);
        repeat (30) @(negedge clk);
        rd_abs(BASE + 'h0E, v);
        repeat (3) @(negedge clk);
        rd_abs(BASE + 'h0F, v);
        check(v == m_rdata, "R10 latched lower at divide-by-8", v, m_rdata);
        wr('h24, 0);

        // R3: channel 2 match sets bit 0x40
        t = (m_cnt + 60) & 'hFFFF;
        wr('h18, t >> 8);
        wr('h19, t & 255);
        repeat (20) @(negedge clk);
        rd_exp('h23, 'h00, "R3 no flag before match");
        repeat (60) @(negedge clk);
        rd_exp('h23, 'h40, "R3 channel 2 flag after match");
        check(irq == 1'b0, "R6 masked flag raises no request", int'(irq), 0);

        // R6, R7, R8: unmask channel 2
        wr('h22, 'h40);
        check(irq == 1'b1, "R6 request with flag and mask", int'(irq), 1);
        check(irq_src == 3'd2, "R7 source channel 2", int'(irq_src), 2);
        check(irq_vector == 16'hFFE6, "R8 vector channel 2", int'(irq_vector), 'hFFE6);

        // R4: write-one-to-clear
        wr('h23, 'h00);
        rd_exp('h23, 'h40, "R4 zero write keeps flag");
        wr('h23, 'hBF);
        rd_exp('h23, 'h40, "R4 other ones keep flag");
        wr('h23, 'h40);
        rd_exp('h23, 'h00, "R4 one clears flag");
        check(irq == 1'b0, "R6 request drops after clear", int'(irq), 0);

        // R7: channels 1 and 3 match together; lowest wins
        t = (m_cnt + 60) & 'hFFFF;
        wr('h16, t >> 8); wr('h17, t & 255);
        wr('h1A, t >> 8); wr('h1B, t & 255);
        wr('h22, 'hE0);
        repeat (60) @(negedge clk);
        rd_exp('h23, 'hA0, "R3 channels 1 and 3 flags");
        check(irq_src == 3'd1, "R7 channel 1 wins", int'(irq_src), 1);
        check(irq_vector == 16'hFFE8, "R8 vector channel 1", int'(irq_vector), 'hFFE8);
        wr('h23, 'h80);
        check(irq_src == 3'd3, "R7 channel 3 next", int'(irq_src), 3);
        check(irq_vector == 16'hFFE4, "R8 vector channel 3", int'(irq_vector), 'hFFE4);
        wr('h23, 'h20);
        check(irq == 1'b0, "R6 idle after clears", int'(irq), 0);

        // R11: upper-byte write blocks channel 4 until lower byte
        wr('h1C, ((m_cnt >> 8) + 1) & 255);
        repeat (600) @(negedge clk);
        rd_exp('h23, 'h00, "R11 no match while lower byte pending");
        t = (m_cnt + 60) & 'hFFFF;
        wr('h1C, t >> 8); wr('h1D, t & 255);
        repeat (70) @(negedge clk);
        rd_exp('h23, 'h10, "R11 match after lower byte");
        wr('h23, 'h10);

        // R9: out-of-window accesses are ignored
        wr_abs(BASE + 'h62, 'hFF);
        wr_abs('h2022, 'h00);
        rd_exp('h22, 'hE0, "R9 mask unchanged by foreign writes");
        rd_abs('h2023, v);
        check(v == 'hE0, "R9 foreign read keeps read data", v, 'hE0);

        // R5: overflow after a full counter period
        wr('h22, 'h00);
        wr('h24, 'h80);
        for (int k = 0; k < 70000; k++) begin
            if (irq) break;
            @(negedge clk);
        end
        check(irq == 1'b1, "R6 request on overflow", int'(irq), 1);
        check(irq_src == 3'd6, "R7 overflow source", int'(irq_src), 6);
        check(irq_vector == 16'hFFDE, "R8 overflow vector", int'(irq_vector), 'hFFDE);
        rd_exp('h25, 'h80, "R5 overflow flag set");
        wr('h22, 'h08);
        check(irq_src == 3'd5, "R7 compare wins over overflow", int'(irq_src), 5);
        check(irq_vector == 16'hFFE0, "R8 vector channel 5", int'(irq_vector), 'hFFE0);
        wr('h22, 'h00);
        wr('h25, 'h00);
        rd_exp('h25, 'h80, "R5 zero write keeps overflow");
        wr('h25, 'h80);
        rd_exp('h25, 'h00, "R5 one clears overflow");
        check(irq == 1'b0, "R6 idle after overflow clear", int'(irq), 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule